// File: doc/BRIEF.md
# Prioritized Memory Protection Region Unit

This block decides, for every address presented to it, what kind of access is allowed and how that address may be cached. Software programs eight region descriptors. Each descriptor holds an enable bit, a size code and a base address. Software also programs per-region permission codes for data and for code, and per-region cache attribute bits. All writes go through a single register-write port, and each write lands on the next clock edge.

The lookup itself is purely combinational. Every region compares the address against its own masked window. When several enabled regions cover the address, the one with the highest index wins. The winning region's permission code is then decoded for either privileged or user mode, as chosen by the mode input. A single global enable bypasses the whole mechanism: while it is clear, every address is fully accessible and uncacheable.

Top module: `mpu_region_unit`

## Requirements
- R1: After synchronous active-low reset, every register is cleared and the unit is disabled, so `access_flags` reads 0x07 for any address and mode.
- R2: Writes take effect on the clock edge where `wr_en` is high. The `wr_sel` values are: 0..7 for region descriptor n, 8 for control, 9 for data permissions, 10 for code permissions, 11 for the data-cacheable bits, 12 for the write-back bits and 13 for the instruction-cacheable bits. Only bit 0 of the control word (the unit enable) has any effect.
- R3: While the unit is disabled, `access_flags` is 0x07: readable, writable, executable, with no cache attributes, whatever the address, the mode and the other registers.
- R4: A region descriptor holds the enable in bit 0, the size code s in bits 5:1 and the base in bits 31:12. The region covers 2^(s+1) bytes. Address and base are compared after the low s+1 bits of both are masked off, so a base that is not aligned to the region size is rounded down.
- R5: Size codes below 11 behave as code 11, giving a 4 KiB region. Descriptor bits 11:6 are ignored.
- R6: With the unit enabled, an address that no enabled region covers gives `access_flags` = 0.
- R7: When enabled regions overlap, the highest-numbered one alone supplies permissions and attributes. A region whose enable bit is clear never matches.
- R8: Permissions are 4 bits per region, with region n in bits 4n+3:4n. Each code decodes as (privileged / user):
  - 0: none / none
  - 1: read-write / none
  - 2: read-write / read-only
  - 3: read-write / read-write
  - 5: read-only / none
  - 6: read-only / read-only
  - any other code: none / none
  
  `priv`=1 selects the privileged result.
- R9: The data permission code drives readable (bit 0) and writable (bit 1). The code permission code, decoded with the same table, drives executable (bit 2) whenever it grants read.
- R10: For the winning region n, bit n of each attribute register sets the flags. The data-cacheable bit sets bit 4. The write-back bit sets bit 5, but only when the data-cacheable bit is also set. The instruction-cacheable bit sets bit 6. Bit 3 of `access_flags` is always 0.
- R11: `access_flags` follows `addr` and `priv` combinationally. It does not change while those inputs are held and no write has been made.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 4 | Register select (see R2) |
| wr_data | input | 32 | Register write value |
| addr | input | 32 | Address to classify |
| priv | input | 1 | 1 = privileged mode, 0 = user mode |
| access_flags | output | 7 | bit0 read, bit1 write, bit2 execute, bit4 data-cacheable, bit5 write-back, bit6 instruction-cacheable |

## Verification
The bench builds the unit with its defaults: eight regions, 32-bit addresses and 4 KiB granularity. With these values the whole-space size code 31, the clamped small sizes and every permission nibble position up to region 7 can all be reached. Overlaps are stacked three deep (regions 2, 5 and 7 on one window) over a background region 0, which makes priority errors in either direction visible. Window edges are probed one word inside and just outside each region, and the unaligned base and the ignored descriptor bits are exercised on the same region.

// File: rtl/mpu_pkg.sv
`timescale 1ns/1ps
// Package: shared widths, flag positions and the permission decode used by
// the protection unit. Assumes 4-bit permission codes.
package mpu_pkg;
    localparam int FLAG_W    = 7;
    localparam int FL_READ   = 0;
    localparam int FL_WRITE  = 1;
    localparam int FL_EXEC   = 2;
    localparam int FL_DCACHE = 4;
    localparam int FL_WBACK  = 5;
    localparam int FL_ICACHE = 6;
    localparam int PERM_BITS = 4;

    typedef logic [FLAG_W-1:0] flags_t;

    // Decode one permission code for a mode; returns {write, read}.
    function automatic logic [1:0] perm_decode(input logic [PERM_BITS-1:0] code,
                                               input logic is_priv);
        logic [1:0] rw;
        case (code)
            4'd1:    rw = is_priv ? 2'b11 : 2'b00;
            4'd2:    rw = is_priv ? 2'b11 : 2'b01;
            4'd3:    rw = 2'b11;
            4'd5:    rw = is_priv ? 2'b01 : 2'b00;
            4'd6:    rw = 2'b01;
            default: rw = 2'b00;
        endcase
        return rw;
    endfunction
endpackage

// File: rtl/mpu_regfile.sv
`timescale 1ns/1ps
// Module: register storage for the protection unit.
// Holds the region descriptors, the unit enable, both permission words and
// the three per-region attribute vectors. Assumes 4*NUM_REGIONS <= DATA_W.
module mpu_regfile #(
    parameter int NUM_REGIONS = 8,
    parameter int DATA_W      = 32,
    parameter int SEL_W       = 4
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                wr_en,
    input  logic [SEL_W-1:0]                    wr_sel,
    input  logic [DATA_W-1:0]                   wr_data,
    output logic [NUM_REGIONS-1:0][DATA_W-1:0]  region_q,
    output logic                                unit_en,
    output logic [4*NUM_REGIONS-1:0]            dperm_q,
    output logic [4*NUM_REGIONS-1:0]            cperm_q,
    output logic [NUM_REGIONS-1:0]              dc_q,
    output logic [NUM_REGIONS-1:0]              wb_q,
    output logic [NUM_REGIONS-1:0]              ic_q
);
    localparam int PERM_W    = 4 * NUM_REGIONS;
    localparam int SEL_CTRL  = NUM_REGIONS;
    localparam int SEL_DPERM = NUM_REGIONS + 1;
    localparam int SEL_CPERM = NUM_REGIONS + 2;
    localparam int SEL_DC    = NUM_REGIONS + 3;
    localparam int SEL_WB    = NUM_REGIONS + 4;
    localparam int SEL_IC    = NUM_REGIONS + 5;

    genvar g;
    generate
        for (g = 0; g < NUM_REGIONS; g++) begin : g_region
            // Capture region descriptor g.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    region_q[g] <= '0;
                else if (wr_en && wr_sel == SEL_W'(g))
                    region_q[g] <= wr_data;
            end
        end
    endgenerate

    // Capture the control, permission and attribute registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            unit_en <= 1'b0;
            dperm_q <= '0;
            cperm_q <= '0;
            dc_q    <= '0;
            wb_q    <= '0;
            ic_q    <= '0;
        end else if (wr_en) begin
            if (wr_sel == SEL_W'(SEL_CTRL))  unit_en <= wr_data[0];
            if (wr_sel == SEL_W'(SEL_DPERM)) dperm_q <= wr_data[PERM_W-1:0];
            if (wr_sel == SEL_W'(SEL_CPERM)) cperm_q <= wr_data[PERM_W-1:0];
            if (wr_sel == SEL_W'(SEL_DC))    dc_q    <= wr_data[NUM_REGIONS-1:0];
            if (wr_sel == SEL_W'(SEL_WB))    wb_q    <= wr_data[NUM_REGIONS-1:0];
            if (wr_sel == SEL_W'(SEL_IC))    ic_q    <= wr_data[NUM_REGIONS-1:0];
        end
    end
endmodule

// File: rtl/mpu_region_match.sv
`timescale 1ns/1ps
// Module: window comparator for one region.
// Size code s covers 2^(s+1) bytes; codes below SIZE_MIN are clamped.
// Address and base are both masked before the compare. Assumes ADDR_W <= 32.
module mpu_region_match #(
    parameter int ADDR_W    = 32,
    parameter int GRAN_LOG2 = 12,
    parameter int SIZE_MIN  = GRAN_LOG2 - 1
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] desc,
    output logic              hit
);
    localparam int SPAN_W = $clog2(ADDR_W + 1) + 1;

    logic [4:0]        size_code;
    logic [4:0]        size_eff;
    logic [SPAN_W-1:0] span_log2;
    logic [ADDR_W:0]   low_fill;
    logic [ADDR_W-1:0] win_mask;
    logic [ADDR_W-1:0] base_addr;
    logic              unused_desc_bits;

    assign size_code        = desc[5:1];
    assign unused_desc_bits = ^desc[GRAN_LOG2-1:6];

    // Clamp the size code and build the window mask.
    always_comb begin
        size_eff  = (size_code < 5'(SIZE_MIN)) ? 5'(SIZE_MIN) : size_code;
        span_log2 = SPAN_W'(size_eff) + SPAN_W'(1);
        low_fill  = ((ADDR_W+1)'(1) << span_log2) - (ADDR_W+1)'(1);
        win_mask  = ~low_fill[ADDR_W-1:0];
        base_addr = {desc[ADDR_W-1:GRAN_LOG2], {GRAN_LOG2{1'b0}}};
    end

    assign hit = desc[0] && ((addr & win_mask) == (base_addr & win_mask));
endmodule

// File: rtl/mpu_priority_pick.sv
`timescale 1ns/1ps
// Module: fixed-priority selector; the highest-index asserted hit wins.
module mpu_priority_pick #(
    parameter int NUM_REGIONS = 8,
    parameter int IDX_W       = $clog2(NUM_REGIONS)
) (
    input  logic [NUM_REGIONS-1:0] hits,
    output logic                   any_hit,
    output logic [IDX_W-1:0]       win_idx
);
    // Scan upward so later (higher) hits override earlier ones.
    always_comb begin
        any_hit = 1'b0;
        win_idx = '0;
        for (int i = 0; i < NUM_REGIONS; i++) begin
            if (hits[i]) begin
                any_hit = 1'b1;
                win_idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/mpu_region_unit.sv
`timescale 1ns/1ps
// Module: prioritized memory protection region unit (top).
// Classifies an address into access and cache flags from programmed
// regions. The flags are combinational from the register state and inputs.
// Assumes 4*NUM_REGIONS <= 32.
module mpu_region_unit #(
    parameter int NUM_REGIONS = 8,
    parameter int ADDR_W      = 32,
    parameter int GRAN_LOG2   = 12
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                wr_en,
    input  logic [$clog2(NUM_REGIONS+6)-1:0]    wr_sel,
    input  logic [ADDR_W-1:0]                   wr_data,
    input  logic [ADDR_W-1:0]                   addr,
    input  logic                                priv,
    output logic [mpu_pkg::FLAG_W-1:0]          access_flags
);
    import mpu_pkg::*;

    localparam int SEL_W = $clog2(NUM_REGIONS + 6);
    localparam int IDX_W = $clog2(NUM_REGIONS);

    logic [NUM_REGIONS-1:0][ADDR_W-1:0] region_q;
    logic                               unit_en;
    logic [4*NUM_REGIONS-1:0]           dperm_q;
    logic [4*NUM_REGIONS-1:0]           cperm_q;
    logic [NUM_REGIONS-1:0]             dc_q;
    logic [NUM_REGIONS-1:0]             wb_q;
    logic [NUM_REGIONS-1:0]             ic_q;
    logic [NUM_REGIONS-1:0]             hits;
    logic                               any_hit;
    logic [IDX_W-1:0]                   win_idx;
    logic [PERM_BITS-1:0]               dcode;
    logic [PERM_BITS-1:0]               ccode;
    logic [1:0]                         d_rw;
    logic [1:0]                         c_rw;
    flags_t                             flags_d;

    mpu_regfile #(
        .NUM_REGIONS(NUM_REGIONS),
        .DATA_W     (ADDR_W),
        .SEL_W      (SEL_W)
    ) i_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .region_q(region_q),
        .unit_en (unit_en),
        .dperm_q (dperm_q),
        .cperm_q (cperm_q),
        .dc_q    (dc_q),
        .wb_q    (wb_q),
        .ic_q    (ic_q)
    );

    genvar g;
    generate
        for (g = 0; g < NUM_REGIONS; g++) begin : g_match
            mpu_region_match #(
                .ADDR_W   (ADDR_W),
                .GRAN_LOG2(GRAN_LOG2)
            ) i_match (
                .addr(addr),
                .desc(region_q[g]),
                .hit (hits[g])
            );
        end
    endgenerate

    mpu_priority_pick #(
        .NUM_REGIONS(NUM_REGIONS),
        .IDX_W      (IDX_W)
    ) i_pick (
        .hits   (hits),
        .any_hit(any_hit),
        .win_idx(win_idx)
    );

    assign dcode = dperm_q[win_idx*PERM_BITS +: PERM_BITS];
    assign ccode = cperm_q[win_idx*PERM_BITS +: PERM_BITS];
    assign d_rw  = perm_decode(dcode, priv);
    assign c_rw  = perm_decode(ccode, priv);

    // Form the result flags from the enable, the hit state and the winner.
    always_comb begin
        flags_d = '0;
        if (!unit_en) begin
            flags_d[FL_READ]  = 1'b1;
            flags_d[FL_WRITE] = 1'b1;
            flags_d[FL_EXEC]  = 1'b1;
        end else if (any_hit) begin
            flags_d[FL_READ]   = d_rw[0];
            flags_d[FL_WRITE]  = d_rw[1];
            flags_d[FL_EXEC]   = c_rw[0];
            flags_d[FL_DCACHE] = dc_q[win_idx];
            flags_d[FL_WBACK]  = dc_q[win_idx] & wb_q[win_idx];
            flags_d[FL_ICACHE] = ic_q[win_idx];
        end
    end

    assign access_flags = flags_d;
endmodule

// File: rtl/mpu_region_unit_chk.sv
`timescale 1ns/1ps
// Module: assertion checker for the protection unit, bound to the top.
module mpu_region_unit_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic              priv,
    input logic [6:0]        access_flags,
    input logic              unit_en,
    input logic              any_hit
);
    // R3
    disabled_full_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !unit_en |-> access_flags == 7'h07);

    // R6
    no_match_no_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (unit_en && !any_hit) |-> access_flags == 7'h00);

    // R10
    wback_needs_dcache_chk: assert property (@(posedge clk) disable iff (!rst_n)
        access_flags[5] |-> access_flags[4]);

    // R10
    bit3_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        access_flags[3] == 1'b0);

    // R8
    write_implies_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        access_flags[1] |-> access_flags[0]);

    // R11
    held_inputs_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(wr_en) && $stable(addr) && $stable(priv)) |-> $stable(access_flags));
endmodule

bind mpu_region_unit mpu_region_unit_chk #(.ADDR_W(ADDR_W)) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .addr        (addr),
    .priv        (priv),
    .access_flags(access_flags),
    .unit_en     (unit_en),
    .any_hit     (any_hit)
);

// File: tb/test_mpu_region_unit.sv
`timescale 1ns/1ps
// Bench: directed scenarios for the protection unit, one task each.
module test_mpu_region_unit;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en;
    logic [3:0]  wr_sel;
    logic [31:0] wr_data;
    logic [31:0] addr;
    logic        priv;
    logic [6:0]  access_flags;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    mpu_region_unit i_mpu_region_unit (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_sel      (wr_sel),
        .wr_data     (wr_data),
        .addr        (addr),
        .priv        (priv),
        .access_flags(access_flags)
    );

    always #2.5 clk = ~clk;

    // Write one register; it is visible after the capturing edge.
    task automatic wr(input logic [3:0] sel, input logic [31:0] data);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_sel  = sel;
        wr_data = data;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    // Apply an address and mode, then compare the flags.
    task automatic chk(input string req, input logic [31:0] a, input logic p,
                       input logic [6:0] exp);
        addr = a;
        priv = p;
        #1;
        checks++;
        if (access_flags !== exp) begin
            failures++;
            $display("FAIL %s addr=%08h priv=%0d actual=%02h expected=%02h",
                     req, a, p, access_flags, exp);
        end
    endtask

    task automatic t_reset();
        chk("R1", 32'h1234_5678, 1'b1, 7'h07);
        chk("R1", 32'h0000_0000, 1'b0, 7'h07);
    endtask

    task automatic t_enable_empty();
        wr(4'd8, 32'h1);
        chk("R6", 32'h0000_1000, 1'b1, 7'h00);
        chk("R6", 32'hFFFF_FFFC, 1'b0, 7'h00);
    endtask

    task automatic t_whole_space();
        wr(4'd0, 32'h0000_003F);
        wr(4'd9, 32'h3);
        wr(4'd10, 32'h3);
        chk("R4", 32'h1234_5678, 1'b1, 7'h07);
        chk("R4", 32'hFFFF_FFFC, 1'b0, 7'h07);
    endtask

    task automatic t_perm_codes();
        wr(4'd9, 32'h1);
        chk("R8", 32'h0000_2000, 1'b1, 7'h07);
        chk("R8", 32'h0000_2000, 1'b0, 7'h04);
        wr(4'd9, 32'h2);
        chk("R8", 32'h0000_2000, 1'b0, 7'h05);
        wr(4'd9, 32'h5);
        chk("R8", 32'h0000_2000, 1'b1, 7'h05);
        chk("R8", 32'h0000_2000, 1'b0, 7'h04);
        wr(4'd9, 32'h6);
        chk("R8", 32'h0000_2000, 1'b0, 7'h05);
        wr(4'd9, 32'h7);
        chk("R8", 32'h0000_2000, 1'b1, 7'h04);
        wr(4'd9, 32'h3);
        wr(4'd10, 32'h5);
        chk("R9", 32'h0000_2000, 1'b0, 7'h03);
        chk("R9", 32'h0000_2000, 1'b1, 7'h07);
        wr(4'd10, 32'h3);
    endtask

    task automatic t_region_window();
        wr(4'd5, 32'h0200_0029);
        wr(4'd9, 32'h0060_0003);
        wr(4'd10, 32'h0000_0003);
        chk("R4", 32'h0210_0000, 1'b1, 7'h01);
        chk("R4", 32'h021F_FFFC, 1'b0, 7'h01);
        chk("R4", 32'h0220_0000, 1'b1, 7'h07);
        chk("R4", 32'h01FF_FFFC, 1'b1, 7'h07);
    endtask

    task automatic t_priority();
        wr(4'd2, 32'h0200_0029);
        wr(4'd9, 32'h0060_0303);
        wr(4'd10, 32'h0000_0303);
        chk("R7", 32'h0210_0000, 1'b1, 7'h01);
        wr(4'd7, 32'h0200_0029);
        wr(4'd10, 32'h3000_0303);
        chk("R7", 32'h0210_0000, 1'b1, 7'h04);
        wr(4'd7, 32'h0200_0028);
        chk("R7", 32'h0210_0000, 1'b1, 7'h01);
        wr(4'd5, 32'h0200_0028);
        chk("R7", 32'h0210_0000, 1'b1, 7'h07);
        wr(4'd5, 32'h0200_0029);
    endtask

    task automatic t_small_size();
        wr(4'd6, 32'h0300_0007);
        wr(4'd9, 32'h0160_0303);
        chk("R5", 32'h0300_0FFC, 1'b1, 7'h03);
        chk("R5", 32'h0300_0FFC, 1'b0, 7'h00);
        chk("R5", 32'h0300_1000, 1'b1, 7'h07);
        wr(4'd6, 32'h0300_0FC7);
        chk("R5", 32'h0300_0000, 1'b1, 7'h03);
        chk("R5", 32'h0300_1000, 1'b1, 7'h07);
    endtask

    task automatic t_unaligned_base();
        wr(4'd6, 32'h0300_401F);
        chk("R4", 32'h0300_0010, 1'b1, 7'h03);
        chk("R4", 32'h0300_FFFC, 1'b1, 7'h03);
        chk("R4", 32'h0301_0000, 1'b1, 7'h07);
    endtask

    task automatic t_cache_attr();
        wr(4'd11, 32'h20);
        wr(4'd12, 32'h20);
        wr(4'd13, 32'h01);
        chk("R10", 32'h0210_0000, 1'b1, 7'h31);
        chk("R10", 32'h0000_1000, 1'b1, 7'h47);
        wr(4'd11, 32'h00);
        chk("R10", 32'h0210_0000, 1'b1, 7'h01);
    endtask

    task automatic t_disable();
        wr(4'd8, 32'hFFFF_FFFE);
        chk("R2", 32'h0210_0000, 1'b1, 7'h07);
        chk("R3", 32'h0000_1000, 1'b0, 7'h07);
        wr(4'd8, 32'h1);
        chk("R2", 32'h0210_0000, 1'b1, 7'h01);
    endtask

    // Watchdog: a hung run is a failure and still reports.
    initial begin
        #100us;
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst_n   = 1'b0;
        wr_en   = 1'b0;
        wr_sel  = '0;
        wr_data = '0;
        addr    = '0;
        priv    = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_enable_empty();
        t_whole_space();
        t_perm_codes();
        t_region_window();
        t_priority();
        t_small_size();
        t_unaligned_base();
        t_cache_attr();
        t_disable();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule